// File: doc/BRIEF.md
# PLL Reference Select and Coast Gate

This block is the digital front end of a phase-locked loop. It runs on the local oscillator clock and produces the single-cycle reference pulse that the phase detector compares against its feedback. The reference comes from one of two sources. One is an asynchronous horizontal sync input, which is synchronized and used on a rising or falling edge as configured. The other is an internal divider that emits one oscillator period high followed by N+1 periods low.

The block also controls the charge-pump enable. An external coast input can hold the loop frequency while sync is unreliable. Its active level is configurable, and a force bit overrides it. Losing the enable condition turns the pump off at once. Regaining it turns the pump back on only after the second reference pulse. A status pin can show nothing, the lock flag, or the reference waveform.

Top module: `refsel_coast_top`

## Requirements
- R1: While reset is held (after at least two clock edges), `ref_pulse_o` is 0. With both status enables at 0, `stat_pin_o` is 0. With `cp_force_i`=1, `cp_en_o` is 1. In the first cycle after reset, `ref_pulse_o` is still 0.
- R2: With `src_osc_i`=1 and a divider field N in 1..127, `ref_pulse_o` is high for one clock every N+2 clocks.
- R3: A divider field of 0 is treated as 1, giving a reference period of 3 clocks.
- R4: A new divider field is taken at the end of the current reference period. The period in progress keeps its old length.
- R5: With `src_osc_i`=0, the reference is `hsync_in` after a two-flop synchronizer. An active edge applied between clock edges gives a one-cycle `ref_pulse_o` in the cycle that follows the second clock edge.
- R6: `ref_neg_i`=0 makes the rising edge of `hsync_in` active, and `ref_neg_i`=1 makes the falling edge active. The inactive edge produces no pulse.
- R7: With `cp_force_i`=1, `cp_en_o` is 1 whatever `coast_in` does.
- R8: With `cp_force_i`=0, the enable condition is `coast_in`=1 when `coast_low_i`=0, and `coast_in`=0 when `coast_low_i`=1.
- R9: When the enable condition goes false, `cp_en_o` drops in the same cycle, through a combinational path.
- R10: After the condition is true again and has passed the two-flop synchronizer, `cp_en_o` returns to 1 in the clock after the second `ref_pulse_o`. Before that it stays 0.
- R11: Status code {`show_ref_i`,`show_lock_i`}: 00 drives 0. 01 drives `lock_in`. 10 is reserved and drives 0.
- R12: Status code 11 drives the synchronized `hsync_in` XOR `ref_neg_i` when `src_osc_i`=0. When `src_osc_i`=1 it drives the divider waveform, which is high in the same cycle as the divider's reference pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Conditioned horizontal sync, asynchronous |
| coast_in | input | 1 | Coast request, asynchronous |
| lock_in | input | 1 | Lock flag from the loop |
| src_osc_i | input | 1 | Reference source: 0 sync input, 1 oscillator divider |
| ref_neg_i | input | 1 | Sync active edge: 0 rising, 1 falling |
| div_sel_i | input | DIV_W | Oscillator divider field N |
| cp_force_i | input | 1 | Keep the charge pump always on |
| coast_low_i | input | 1 | Coast input polarity: 1 means enable while low |
| show_lock_i | input | 1 | Status pin enable for lock |
| show_ref_i | input | 1 | Status pin enable for reference |
| ref_pulse_o | output | 1 | One-cycle reference pulse to the phase detector |
| cp_en_o | output | 1 | Charge-pump enable |
| stat_pin_o | output | 1 | Status pin |

## Verification
The hardest state to reach is a charge pump that is still off after the coast condition has returned. This is the window in which reference pulses seen before the synchronizer catches up must not count toward re-arming. The stimulus sets the divider to its shortest period, so pulses arrive every three clocks. It then releases coast at a known cycle and samples `cp_en_o` on every cycle until the second counted pulse. A reference model in the bench, built from queues and counters, is compared against all three outputs on every clock.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int SYNC_DEPTH        = 2;
    localparam int REARM_EDGES_DFLT  = 2;

    typedef enum logic {
        SRC_HSYNC = 1'b0,
        SRC_OSC   = 1'b1
    } ref_src_e;

    typedef enum logic [1:0] {
        STAT_OFF  = 2'b00,
        STAT_LOCK = 2'b01,
        STAT_RSVD = 2'b10,
        STAT_REF  = 2'b11
    } stat_mode_e;

    typedef struct packed {
        logic force_on;
        logic coast_low;
    } cp_cfg_t;

    function automatic stat_mode_e stat_mode(input logic show_ref, input logic show_lock);
        return stat_mode_e'({show_ref, show_lock});
    endfunction

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '0;
                    else     stg[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '0;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/refsel_osc_div.sv
module refsel_osc_div #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    output logic             div_hi
);
    localparam int PH_W = DIV_W + 1;

    logic [PH_W-1:0]  phase_q;
    logic [DIV_W-1:0] n_q;
    logic             last;

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] f);
        return (f == '0) ? DIV_W'(1) : f;
    endfunction

    assign last = (phase_q == ({1'b0, n_q} + PH_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            n_q     <= eff_div(div_sel);
        end else if (last) begin
            phase_q <= '0;
            n_q     <= eff_div(div_sel);
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    assign div_hi = (phase_q == '0);
endmodule

// File: rtl/refsel_cp_gate.sv
module refsel_cp_gate
    import refsel_pkg::*;
#(
    parameter int REARM_EDGES = REARM_EDGES_DFLT
) (
    input  logic    clk,
    input  logic    rst,
    input  cp_cfg_t cfg,
    input  logic    coast_raw,
    input  logic    coast_sync,
    input  logic    ref_pulse,
    output logic    armed,
    output logic    cp_en
);
    localparam int CNT_W = $clog2(REARM_EDGES + 1);

    logic             arm_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cond_sync;
    logic             cond_raw;

    assign cond_sync = coast_sync ^ cfg.coast_low;
    assign cond_raw  = coast_raw  ^ cfg.coast_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b1;
            cnt_q <= '0;
        end else if (cfg.force_on) begin
            arm_q <= 1'b1;
            cnt_q <= '0;
        end else if (!cond_sync) begin
            arm_q <= 1'b0;
            cnt_q <= '0;
        end else if (!arm_q && ref_pulse) begin
            if (cnt_q == CNT_W'(REARM_EDGES - 1)) begin
                arm_q <= 1'b1;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // disable path: the live condition masks the armed flop without a clock
    assign cp_en = cfg.force_on | (arm_q & cond_raw);
    assign armed = arm_q;
endmodule

// File: rtl/refsel_status.sv
module refsel_status
    import refsel_pkg::*;
(
    input  stat_mode_e mode,
    input  ref_src_e   src,
    input  logic       lock_in,
    input  logic       hs_lvl,
    input  logic       div_hi,
    output logic       stat
);
    always_comb begin
        case (mode)
            STAT_LOCK: stat = lock_in;
            STAT_REF:  stat = (src == SRC_OSC) ? div_hi : hs_lvl;
            default:   stat = 1'b0;
        endcase
    end
endmodule

// File: rtl/refsel_coast_top.sv
module refsel_coast_top
    import refsel_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int REARM_EDGES = REARM_EDGES_DFLT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_in,
    input  logic             coast_in,
    input  logic             lock_in,
    input  logic             src_osc_i,
    input  logic             ref_neg_i,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic             cp_force_i,
    input  logic             coast_low_i,
    input  logic             show_lock_i,
    input  logic             show_ref_i,
    output logic             ref_pulse_o,
    output logic             cp_en_o,
    output logic             stat_pin_o
);
    logic [1:0] sync_q;
    logic       hs_sync;
    logic       coast_sync;
    logic       hs_lvl;
    logic       div_hi;
    logic       sel_lvl;
    logic       sel_prev_q;
    logic       cp_armed;
    ref_src_e   src;
    cp_cfg_t    cp_cfg;

    assign src    = ref_src_e'(src_osc_i);
    assign cp_cfg = '{force_on: cp_force_i, coast_low: coast_low_i};

    refsel_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({coast_in, hsync_in}),
        .q   (sync_q)
    );
    assign hs_sync    = sync_q[0];
    assign coast_sync = sync_q[1];

    refsel_osc_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel_i),
        .div_hi  (div_hi)
    );

    assign hs_lvl  = hs_sync ^ ref_neg_i;
    assign sel_lvl = (src == SRC_OSC) ? div_hi : hs_lvl;

    always_ff @(posedge clk) begin
        if (rst) sel_prev_q <= 1'b1;
        else     sel_prev_q <= sel_lvl;
    end

    assign ref_pulse_o = sel_lvl & ~sel_prev_q;

    refsel_cp_gate #(.REARM_EDGES(REARM_EDGES)) u_cp (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cp_cfg),
        .coast_raw  (coast_in),
        .coast_sync (coast_sync),
        .ref_pulse  (ref_pulse_o),
        .armed      (cp_armed),
        .cp_en      (cp_en_o)
    );

    refsel_status u_stat (
        .mode    (stat_mode(show_ref_i, show_lock_i)),
        .src     (src),
        .lock_in (lock_in),
        .hs_lvl  (hs_lvl),
        .div_hi  (div_hi),
        .stat    (stat_pin_o)
    );
endmodule

// File: rtl/refsel_coast_chk.sv
module refsel_coast_chk (
    input logic clk,
    input logic rst,
    input logic cp_force,
    input logic coast_in,
    input logic coast_low,
    input logic show_lock,
    input logic show_ref,
    input logic lock_in,
    input logic src_osc,
    input logic ref_pulse,
    input logic cp_en,
    input logic stat,
    input logic cp_armed
);
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);

    p_osc_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && src_osc) |=> !(ref_pulse && src_osc));

    p_force_on_r7: assert property (@(posedge clk) disable iff (rst)
        (cp_force && $past(cp_force)) |-> cp_en);

    p_coast_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (!cp_force && !(coast_in ^ coast_low)) |-> !cp_en);

    p_rearm_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(cp_armed) |-> ($past(ref_pulse) || $past(cp_force)));

    p_stat_off_r11: assert property (@(posedge clk) disable iff (rst)
        (!show_lock && !show_ref) |-> !stat);

    p_stat_lock_r11: assert property (@(posedge clk) disable iff (rst)
        (show_lock && !show_ref) |-> (stat == lock_in));
endmodule

bind refsel_coast_top refsel_coast_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cp_force  (cp_force_i),
    .coast_in  (coast_in),
    .coast_low (coast_low_i),
    .show_lock (show_lock_i),
    .show_ref  (show_ref_i),
    .lock_in   (lock_in),
    .src_osc   (src_osc_i),
    .ref_pulse (ref_pulse_o),
    .cp_en     (cp_en_o),
    .stat      (stat_pin_o),
    .cp_armed  (cp_armed)
);

// File: tb/refsel_coast_top_tb_top.sv
module refsel_coast_top_tb_top;
    localparam int DIV_W = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_in = 1'b0, coast_in = 1'b1, lock_in = 1'b0;
    logic src_osc_i = 1'b1, ref_neg_i = 1'b0, cp_force_i = 1'b1, coast_low_i = 1'b0;
    logic show_lock_i = 1'b0, show_ref_i = 1'b0;
    logic [DIV_W-1:0] div_sel_i = 7'd4;
    logic ref_pulse_o, cp_en_o, stat_pin_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    refsel_coast_top #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .coast_in(coast_in),
        .lock_in(lock_in), .src_osc_i(src_osc_i), .ref_neg_i(ref_neg_i),
        .div_sel_i(div_sel_i), .cp_force_i(cp_force_i), .coast_low_i(coast_low_i),
        .show_lock_i(show_lock_i), .show_ref_i(show_ref_i),
        .ref_pulse_o(ref_pulse_o), .cp_en_o(cp_en_o), .stat_pin_o(stat_pin_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_ph = 0, m_n = 1, m_cnt = 0;
    bit m_prev = 1, m_arm = 1, m_valid = 0;
    bit hs_q[$] = '{0, 0};
    bit co_q[$] = '{0, 0};

    function automatic int eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic bit exp_lvl();
        if (src_osc_i) return (m_ph == 0);
        return hs_q[0] ^ ref_neg_i;
    endfunction

    function automatic bit exp_stat();
        case ({show_ref_i, show_lock_i})
            2'b01:   return lock_in;
            2'b11:   return src_osc_i ? (m_ph == 0) : (hs_q[0] ^ ref_neg_i);
            default: return 1'b0;
        endcase
    endfunction

    always begin
        @(posedge clk);
        if (rst) begin
            m_ph = 0; m_n = eff(int'(div_sel_i)); m_prev = 1; m_arm = 1; m_cnt = 0;
            hs_q = '{0, 0}; co_q = '{0, 0}; m_valid = 1;
        end else begin
            bit lvl, pulse, cond_s;
            lvl = exp_lvl();
            pulse = lvl & !m_prev;
            cond_s = co_q[0] ^ coast_low_i;
            if (cp_force_i) begin m_arm = 1; m_cnt = 0; end
            else if (!cond_s) begin m_arm = 0; m_cnt = 0; end
            else if (!m_arm && pulse) begin
                m_cnt++;
                if (m_cnt == 2) begin m_arm = 1; m_cnt = 0; end
            end
            m_prev = lvl;
            if (m_ph == m_n + 1) begin m_ph = 0; m_n = eff(int'(div_sel_i)); end
            else m_ph++;
            hs_q.push_back(hsync_in); void'(hs_q.pop_front());
            co_q.push_back(coast_in); void'(co_q.pop_front());
        end
        #3;
        if (!rst && m_valid && !done) begin
            chk("R5 reference pulse", ref_pulse_o, exp_lvl() & !m_prev);
            chk("R10 charge-pump enable", cp_en_o,
                cp_force_i | (m_arm & (coast_in ^ coast_low_i)));
            chk("R12 status pin", stat_pin_o, exp_stat());
        end
    end

    // ---------------- helpers ----------------
    task automatic drive_slot();
        @(posedge clk); #1;
    endtask

    task automatic sample_slot();
        @(posedge clk); #3;
    endtask

    task automatic wait_pulse(output int cyc);
        cyc = 0;
        do begin
            sample_slot();
            cyc++;
        end while (!ref_pulse_o && cyc < 1000);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int p;
        int n;
        repeat (3) sample_slot();
        chk("R1 pulse in reset", ref_pulse_o, 1'b0);
        chk("R1 status in reset", stat_pin_o, 1'b0);
        chk("R1 cp_en in reset", cp_en_o, 1'b1);
        drive_slot(); rst = 1'b0;
        sample_slot();
        chk("R1 no pulse after reset", ref_pulse_o, 1'b0);

        // divider period
        wait_pulse(p);
        wait_pulse(p);
        chk_int("R2 period N=4", p, 6);
        drive_slot(); div_sel_i = 7'd9;
        wait_pulse(p);
        chk_int("R4 old period kept", p + 1, 6);
        wait_pulse(p);
        chk_int("R4 new period N=9", p, 11);
        drive_slot(); div_sel_i = 7'd0;
        wait_pulse(p); wait_pulse(p); wait_pulse(p);
        chk_int("R3 field zero period", p, 3);

        // status on oscillator reference
        drive_slot(); show_lock_i = 1'b1; show_ref_i = 1'b1;
        repeat (6) begin
            sample_slot();
            chk("R12 status equals divider pulse", stat_pin_o, ref_pulse_o);
        end
        drive_slot(); show_ref_i = 1'b0; lock_in = 1'b1;
        #2; chk("R11 lock shown", stat_pin_o, 1'b1);
        drive_slot(); lock_in = 1'b0;
        #2; chk("R11 lock low shown", stat_pin_o, 1'b0);
        drive_slot(); show_lock_i = 1'b0; show_ref_i = 1'b1; lock_in = 1'b1;
        #2; chk("R11 reserved drives 0", stat_pin_o, 1'b0);
        drive_slot(); show_ref_i = 1'b0;
        #2; chk("R11 off drives 0", stat_pin_o, 1'b0);

        // coast behaviour with fast oscillator reference (period 3)
        drive_slot(); cp_force_i = 1'b0; coast_low_i = 1'b0; coast_in = 1'b1;
        repeat (4) sample_slot();
        chk("R8 enabled while coast high", cp_en_o, 1'b1);
        drive_slot(); coast_in = 1'b0;
        #2; chk("R9 immediate disable", cp_en_o, 1'b0);
        repeat (10) sample_slot();
        chk("R9 stays disabled", cp_en_o, 1'b0);
        drive_slot(); coast_in = 1'b1;
        #2;
        n = 0;
        for (int i = 0; i < 30; i++) begin
            if (i > 0) sample_slot();
            if (n == 2) begin
                chk("R10 re-enabled after second pulse", cp_en_o, 1'b1);
                break;
            end
            chk("R10 held off before second pulse", cp_en_o, 1'b0);
            if (i >= 2 && ref_pulse_o) n++;
        end
        chk_int("R10 pulses counted", n, 2);

        drive_slot(); coast_low_i = 1'b1;
        #2; chk("R8 low polarity disables on high coast", cp_en_o, 1'b0);
        drive_slot(); coast_in = 1'b0;
        repeat (20) sample_slot();
        chk("R8 low polarity re-enabled", cp_en_o, 1'b1);
        drive_slot(); cp_force_i = 1'b1; coast_in = 1'b1;
        repeat (5) sample_slot();
        chk("R7 forced enable", cp_en_o, 1'b1);

        // sync input reference
        drive_slot(); src_osc_i = 1'b0; ref_neg_i = 1'b0; hsync_in = 1'b0;
        show_lock_i = 1'b1; show_ref_i = 1'b1;
        repeat (5) sample_slot();
        drive_slot(); hsync_in = 1'b1;
        #2;
        for (int i = 0; i < 4; i++) begin
            if (i > 0) sample_slot();
            chk("R5 rising edge pulse timing", ref_pulse_o, i == 2);
        end
        chk("R12 status shows sync", stat_pin_o, 1'b1);
        drive_slot(); hsync_in = 1'b0;
        for (int i = 0; i < 5; i++) begin
            sample_slot();
            chk("R6 falling edge ignored", ref_pulse_o, 1'b0);
        end
        drive_slot(); hsync_in = 1'b1;
        repeat (4) sample_slot();
        drive_slot(); ref_neg_i = 1'b1;
        repeat (3) sample_slot();
        drive_slot(); hsync_in = 1'b0;
        #2;
        for (int i = 0; i < 4; i++) begin
            if (i > 0) sample_slot();
            chk("R6 falling edge pulse timing", ref_pulse_o, i == 2);
        end
        drive_slot(); hsync_in = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sample_slot();
            chk("R6 rising edge ignored", ref_pulse_o, 1'b0);
        end
        repeat (4) sample_slot();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule